// File: doc/BRIEF.md
# Min-Sum Check Node Unit

This block performs the check-node half of one min-sum decoding iteration for a single parity check of a low-density parity-check code. It takes up to `MAX_DEG` signed bit-to-check messages in parallel, together with a mask that marks which positions are edges of the current check. For each active edge it returns a check-to-bit message. The magnitude of that message is the smallest magnitude seen on the other active edges. Its sign is the XOR of the signs on the other active edges, which keeps the modulo-2 sum of the check's bits at zero.

Checks in a decoder often have different degrees. The mask lets one instance serve checks with 7 to 14 edges without any change to the hardware. Internally the unit reduces all active edges to four values: the smallest magnitude, the second smallest magnitude, the position of the smallest, and the total sign parity. Every output is then built from those four values. The result is registered, and `out_valid` rises one cycle after `in_valid`.

Messages are 6-bit two's complement values (1 integer bit, 5 fractional bits), packed into the flat input and output buses with edge `i` at bits `[6*i+5 : 6*i]`.

Top module: `cnu_minsum_top`

## Requirements
- R1: For every active edge, the output magnitude equals the minimum of the magnitudes on all other active edges. The edge's own input does not take part.
- R2: For every active edge, the output sign is the XOR of the sign bits (bit 5, 1 = negative) of all other active inputs. The output is the two's complement of the magnitude when that sign is 1, and the plain magnitude otherwise. A zero magnitude always gives 0.
- R3: An edge whose mask bit is 0 outputs 0. Its input value has no effect on any other edge's output.
- R4: The input value -32 (6'b100000) is treated as magnitude 31. Every other negative value v has magnitude -v.
- R5: When one active edge holds a strictly smallest magnitude, that edge receives the second smallest magnitude. When two or more active edges tie for the smallest, every active edge receives the tied value.
- R6: When only one edge is active, its output is +31. When no edge is active, all outputs are 0.
- R7: `out_valid` is high exactly in the cycle after `in_valid` was sampled high. `out_msgs` updates only on such samples and otherwise holds its value. Back-to-back inputs give back-to-back results.
- R8: While `rst` is high at a clock edge, `out_valid` and `out_msgs` are cleared to 0.
- R9: Any mask pattern is accepted, with any number of edges and edges in any positions. This covers row weights from 7 to 14 placed anywhere in the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input messages and mask are valid this cycle |
| in_msgs | input | 84 | Bit-to-check messages, 6 bits per edge, edge 0 in the low bits |
| in_mask | input | 14 | Active-edge mask, bit i enables edge i |
| out_valid | output | 1 | Output messages are valid |
| out_msgs | output | 84 | Check-to-bit messages, same packing as the input |

## Verification
The hardest situations to reach through the ports involve the relation between the minimum and the mask. One is a tie for the smallest magnitude. Another is an inactive edge that carries a value smaller than any active one. A third is -32 sitting where the minimum is chosen. Uniform random 6-bit inputs rarely produce a tie at the minimum under a sparse mask. For that reason the random stimulus draws many magnitudes from a small set of values near zero and mixes in -32. It also pairs each mask with random data on the masked-off positions. Directed vectors then force exact ties, a lone active edge, an empty mask, and a hidden small value on a disabled edge.

// File: rtl/cnu_pkg.sv
package cnu_pkg;

    parameter int MAX_DEG = 14;
    parameter int MSG_W   = 6;

    localparam int MAG_W  = MSG_W - 1;
    localparam int IDX_W  = (MAX_DEG > 1) ? $clog2(MAX_DEG) : 1;
    localparam int BUS_W  = MAX_DEG * MSG_W;

    typedef logic [MAG_W-1:0] mag_t;
    typedef logic [MSG_W-1:0] msg_t;
    typedef logic [IDX_W-1:0] idx_t;

    localparam mag_t MAG_MAX = '1;

    typedef struct packed {
        logic act;
        logic sgn;
        mag_t mag;
    } edge_t;

    typedef struct packed {
        logic any;
        logic par;
        mag_t min1;
        mag_t min2;
        idx_t idx1;
    } reduce_t;

    // Magnitude of a two's complement message, most negative code saturated.
    function automatic mag_t sat_mag(input msg_t v);
        msg_t neg;
        if (!v[MSG_W-1]) begin
            return v[MAG_W-1:0];
        end
        neg = (~v) + msg_t'(1);
        if (neg[MSG_W-1]) begin
            return MAG_MAX;
        end
        return neg[MAG_W-1:0];
    endfunction

    // Rebuild a signed message from sign and magnitude.
    function automatic msg_t pack_msg(input logic sgn, input mag_t mag);
        msg_t pos;
        pos = {1'b0, mag};
        if (sgn) begin
            return (~pos) + msg_t'(1);
        end
        return pos;
    endfunction

endpackage

// File: rtl/cnu_edge_unpack.sv
module cnu_edge_unpack
    import cnu_pkg::*;
(
    input  logic [BUS_W-1:0]   msgs,
    input  logic [MAX_DEG-1:0] mask,
    output edge_t              edges [MAX_DEG]
);

    for (genvar e = 0; e < MAX_DEG; e++) begin : g_edge
        msg_t raw;
        assign raw = msgs[e*MSG_W +: MSG_W];
        always_comb begin
            edges[e].act = mask[e];
            edges[e].sgn = mask[e] & raw[MSG_W-1];
            edges[e].mag = mask[e] ? sat_mag(raw) : MAG_MAX;
        end
    end

endmodule

// File: rtl/cnu_reduce.sv
module cnu_reduce
    import cnu_pkg::*;
(
    input  edge_t   edges [MAX_DEG],
    output reduce_t red
);

    always_comb begin
        reduce_t acc;
        acc.any  = 1'b0;
        acc.par  = 1'b0;
        acc.min1 = MAG_MAX;
        acc.min2 = MAG_MAX;
        acc.idx1 = '0;
        for (int e = 0; e < MAX_DEG; e++) begin
            if (edges[e].act) begin
                acc.par = acc.par ^ edges[e].sgn;
                if (!acc.any || edges[e].mag < acc.min1) begin
                    acc.min2 = acc.min1;
                    acc.min1 = edges[e].mag;
                    acc.idx1 = idx_t'(e);
                end else if (edges[e].mag < acc.min2) begin
                    acc.min2 = edges[e].mag;
                end
                acc.any = 1'b1;
            end
        end
        red = acc;
    end

endmodule

// File: rtl/cnu_out_stage.sv
module cnu_out_stage
    import cnu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  edge_t            edges [MAX_DEG],
    input  reduce_t          red,
    output logic             out_valid,
    output logic [BUS_W-1:0] out_msgs
);

    logic [BUS_W-1:0] nxt;

    for (genvar e = 0; e < MAX_DEG; e++) begin : g_out
        logic sgn_ext;
        mag_t mag_ext;
        always_comb begin
            sgn_ext = red.par ^ edges[e].sgn;
            mag_ext = (red.idx1 == idx_t'(e)) ? red.min2 : red.min1;
            if (edges[e].act) begin
                nxt[e*MSG_W +: MSG_W] = pack_msg(sgn_ext, mag_ext);
            end else begin
                nxt[e*MSG_W +: MSG_W] = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_msgs  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_msgs <= nxt;
            end
        end
    end

endmodule

// File: rtl/cnu_minsum_top.sv
module cnu_minsum_top
    import cnu_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [BUS_W-1:0]   in_msgs,
    input  logic [MAX_DEG-1:0] in_mask,
    output logic               out_valid,
    output logic [BUS_W-1:0]   out_msgs
);

    edge_t   edges [MAX_DEG];
    reduce_t red;

    cnu_edge_unpack u_unpack (
        .msgs  (in_msgs),
        .mask  (in_mask),
        .edges (edges)
    );

    cnu_reduce u_reduce (
        .edges (edges),
        .red   (red)
    );

    cnu_out_stage u_out (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .edges     (edges),
        .red       (red),
        .out_valid (out_valid),
        .out_msgs  (out_msgs)
    );

    // R7: one-cycle valid pipeline and hold between samples
    assert_valid_rise_R7: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_valid_fall_R7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_msgs));

    // R5: reduction ordering and index sanity
    assert_min_order_R5: assert property (@(posedge clk) disable iff (rst)
        red.any |-> (red.min1 <= red.min2));
    assert_idx_active_R5: assert property (@(posedge clk) disable iff (rst)
        (in_mask != '0) |-> in_mask[red.idx1]);
    assert_empty_R6: assert property (@(posedge clk) disable iff (rst)
        (in_mask == '0) |-> !red.any);

    for (genvar e = 0; e < MAX_DEG; e++) begin : g_chk
        // R3: disabled edges drive zero one cycle later
        assert_mask_zero_R3: assert property (@(posedge clk) disable iff (rst)
            (in_valid && !in_mask[e]) |=> (out_msgs[e*MSG_W +: MSG_W] == '0));
        // R1: min1 never exceeds any active magnitude
        assert_min_bound_R1: assert property (@(posedge clk) disable iff (rst)
            edges[e].act |-> (red.min1 <= edges[e].mag));
        // R4: most negative input seen as full-scale magnitude
        assert_sat_R4: assert property (@(posedge clk) disable iff (rst)
            (in_mask[e] && in_msgs[e*MSG_W +: MSG_W] == {1'b1, {MAG_W{1'b0}}})
            |-> (edges[e].mag == MAG_MAX));
    end

endmodule

// File: tb/cnu_minsum_top_tb_top.sv
module cnu_minsum_top_tb_top;

    localparam int DEG = 14;
    localparam int W   = 6;
    localparam int BW  = DEG * W;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [BW-1:0] in_msgs = '0;
    logic [DEG-1:0] in_mask = '0;
    logic          out_valid;
    logic [BW-1:0] out_msgs;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cnu_minsum_top dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_msgs   (in_msgs),
        .in_mask   (in_mask),
        .out_valid (out_valid),
        .out_msgs  (out_msgs)
    );

    function automatic int mag_of(input logic [W-1:0] v);
        int s;
        s = $signed(v);
        if (s < 0) s = -s;
        if (s > 31) s = 31;
        return s;
    endfunction

    // Brute force: every edge scans every other edge directly.
    function automatic logic [BW-1:0] model(input logic [BW-1:0] m, input logic [DEG-1:0] k);
        logic [BW-1:0] r;
        r = '0;
        for (int i = 0; i < DEG; i++) begin
            if (k[i]) begin
                int best;
                logic sg;
                int val;
                best = 31;
                sg = 1'b0;
                for (int j = 0; j < DEG; j++) begin
                    if (j != i && k[j]) begin
                        if (mag_of(m[j*W +: W]) < best) best = mag_of(m[j*W +: W]);
                        sg = sg ^ m[j*W + W - 1];
                    end
                end
                val = sg ? -best : best;
                r[i*W +: W] = W'(val);
            end
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [BW-1:0] act, input logic [BW-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_bit(input string req, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Drive one vector, check result on the following cycle, then one idle cycle.
    task automatic apply(input string req, input logic [BW-1:0] m, input logic [DEG-1:0] k);
        logic [BW-1:0] exp;
        exp = model(m, k);
        @(negedge clk);
        in_valid = 1'b1;
        in_msgs  = m;
        in_mask  = k;
        @(negedge clk);
        in_valid = 1'b0;
        in_msgs  = {$urandom, $urandom, $urandom};
        check_bit({req, " valid"}, out_valid, 1'b1);
        check(req, out_msgs, exp);
        @(negedge clk);
        // R7: idle cycle, outputs hold
        check_bit("R7 idle valid", out_valid, 1'b0);
        check("R7 hold", out_msgs, exp);
    endtask

    function automatic logic [W-1:0] rnd_msg();
        int sel;
        sel = $urandom_range(0, 9);
        if (sel < 5) return W'($urandom_range(0, 3) * (($urandom_range(0, 1) == 1) ? -1 : 1));
        if (sel == 5) return 6'b100000;
        return W'($urandom);
    endfunction

    function automatic logic [DEG-1:0] rnd_mask();
        logic [DEG-1:0] k;
        int w;
        if ($urandom_range(0, 4) == 0) return DEG'($urandom);
        w = $urandom_range(7, 14);
        k = '0;
        while ($countones(k) < w) k[$urandom_range(0, DEG - 1)] = 1'b1;
        return k;
    endfunction

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [BW-1:0] m;
        void'($urandom(32'd20240611));

        // R8: reset state, even with input active
        in_valid = 1'b1;
        in_mask  = '1;
        in_msgs  = {DEG{6'd5}};
        repeat (3) @(negedge clk);
        check_bit("R8 reset valid", out_valid, 1'b0);
        check("R8 reset data", out_msgs, '0);
        in_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        check_bit("R8 post-reset valid", out_valid, 1'b0);
        check("R8 post-reset data", out_msgs, '0);

        // R1/R2: all positive, distinct magnitudes
        for (int i = 0; i < DEG; i++) m[i*W +: W] = W'(i + 3);
        apply("R1 distinct", m, '1);
        // R5: unique minimum gets second minimum
        m[5*W +: W] = 6'd1;
        apply("R5 unique min", m, '1);
        // R5: tie at minimum
        m[9*W +: W] = 6'd1;
        apply("R5 tie", m, '1);
        // R2: mixed signs, zero magnitude
        m[2*W +: W] = 6'd0;
        m[7*W +: W] = W'(-7);
        m[11*W +: W] = W'(-2);
        apply("R2 signs", m, '1);
        // R4: most negative value everywhere
        apply("R4 all -32", {DEG{6'b100000}}, '1);
        m = {DEG{6'd20}};
        m[0] = 1'b0;
        m[3*W +: W] = 6'b100000;
        apply("R4 one -32", m, 14'h00ff);
        // R3: hidden small value on a disabled edge
        m = {DEG{6'd12}};
        m[4*W +: W] = W'(-1);
        apply("R3 masked small", m, 14'h3fef);
        // R6: single active edge and empty mask
        apply("R6 single", m, 14'h0400);
        apply("R6 empty", m, '0);
        // R9: weight 7 at scattered positions, weight 11
        apply("R9 weight7", {$urandom, $urandom, $urandom}, 14'h2a55);
        apply("R9 weight11", {$urandom, $urandom, $urandom}, 14'h3bf3);

        // R7: back-to-back stream
        begin
            logic [BW-1:0] ms [3];
            logic [DEG-1:0] ks [3];
            for (int v = 0; v < 3; v++) begin
                for (int i = 0; i < DEG; i++) ms[v][i*W +: W] = rnd_msg();
                ks[v] = rnd_mask();
            end
            @(negedge clk);
            for (int v = 0; v < 3; v++) begin
                in_valid = 1'b1;
                in_msgs = ms[v];
                in_mask = ks[v];
                @(negedge clk);
                check_bit("R7 stream valid", out_valid, 1'b1);
                check("R7 stream data", out_msgs, model(ms[v], ks[v]));
            end
            in_valid = 1'b0;
        end

        // R1/R2/R3/R5/R9: constrained random
        for (int t = 0; t < 400; t++) begin
            for (int i = 0; i < DEG; i++) m[i*W +: W] = rnd_msg();
            apply("R1 R2 R3 R5 R9 random", m, rnd_mask());
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule